// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This unit timestamps transitions on an external, asynchronous capture pin against a free-running counter that another block supplies. A control bit chooses whether rising or falling transitions count. When a transition of the chosen direction is seen, the unit stores the counter value in a capture register and raises a capture flag. Both happen on the same clock edge.

The flag stays up until software clears it with a strobe. A further transition overwrites the stored value whether or not the flag has been cleared. Software reads the 16-bit stored value one byte at a time and must read the low byte first. That read parks the high byte in a holding register. The later high-byte read returns the parked byte, so the two halves always belong to the same capture.

The pin passes through a two-stage synchronizer before edge detection. The detector compares two successive synchronized levels. Changing the direction bit while the pin is quiet therefore produces no event.

Top module: `icap_unit`

## Requirements
- R1: With `rise_sel_i` = 1, a low-to-high transition of `cap_pin_i` causes a capture, and a high-to-low transition causes none.
- R2: With `rise_sel_i` = 0, a high-to-low transition of `cap_pin_i` causes a capture, and a low-to-high transition causes none.
- R3: A pin change applied before clock edge N is captured on clock edge N+2. `cap_value_o` then holds the `count_i` value present at edge N+2. With no capture, `cap_value_o` keeps its value.
- R4: `cap_flag_o` rises on the same clock edge that loads `cap_value_o`. It is still low one edge earlier.
- R5: Once set, `cap_flag_o` stays 1 until `flag_clr_i` is sampled high. It is 0 after that edge when no capture happens on that edge.
- R6: When a capture and `flag_clr_i` fall on the same clock edge, `cap_flag_o` is 1 afterwards.
- R7: A capture while `cap_flag_o` is already 1 still replaces `cap_value_o` with the new counter value.
- R8: Toggling `rise_sel_i` while the pin level is steady changes neither `cap_flag_o` nor `cap_value_o`.
- R9: A `rd_lo_i` strobe makes `rd_data_o` equal bits 7:0 of the stored value on the next edge. It also parks bits 15:8 in a holding register. A later `rd_hi_i` strobe (with `rd_lo_i` low) returns the parked byte, even if a capture has occurred in between. If both strobes are high, the low read wins.
- R10: After the synchronous active-high reset, `cap_value_o`, `cap_flag_o` and `rd_data_o` are 0. No capture occurs during the first three edges after reset, whatever the pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| rise_sel_i | input | 1 | 1 = rising transitions capture, 0 = falling |
| count_i | input | CNT_W | Live counter value |
| flag_clr_i | input | 1 | Clears the capture flag |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| cap_value_o | output | CNT_W | Stored counter snapshot |
| cap_flag_o | output | 1 | Capture flag |
| rd_data_o | output | CNT_W/2 | Byte returned by the last read strobe |

## Verification
The hardest case to reach is a torn read: a capture that lands between the low-byte read and the high-byte read. Reaching it takes a pin transition timed so that its delayed capture edge falls after the low strobe and before the high strobe. The stimulus lets one capture complete, performs the low read, runs a complete second capture, and only then issues the high read. It then checks that the returned byte belongs to the first value. A second hard case is a clear landing on exactly the capture edge. It is reached by raising the clear strobe in the cycle just before the counted third edge after a pin change.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_SYNC  = 2;

  // Transition test between the previous and present synchronized levels.
  function automatic logic edge_hit(input logic rise_sel, input logic now_lvl,
                                    input logic old_lvl);
    return rise_sel ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
  endfunction
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/icap_edge.sv
module icap_edge #(
  parameter int unsigned WARM = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  import icap_pkg::*;

  localparam int unsigned WW = $clog2(WARM + 1);

  logic          old_lvl;
  logic [WW-1:0] warm_cnt;
  logic          armed;

  assign armed = (warm_cnt == WW'(WARM));

  always_ff @(posedge clk) begin
    if (rst) begin
      old_lvl  <= 1'b0;
      warm_cnt <= '0;
    end else begin
      old_lvl <= lvl_i;
      if (!armed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  assign hit_o = armed && edge_hit(rise_sel_i, lvl_i, old_lvl);

  // R1/R2: an event always points to the chosen direction
  a_r1_polarity_match: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (lvl_i == rise_sel_i));
  // R8: an event needs a change of the synchronized level
  a_r8_needs_level_change: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (lvl_i != $past(lvl_i)));
endmodule

// File: rtl/icap_snapshot.sv
module icap_snapshot #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (hit_i) cap_o <= count_i;
      if (hit_i)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  a_r4_flag_with_load: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> (flag_o && cap_o == $past(count_i)));
  a_r6_capture_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (hit_i && clr_i) |=> flag_o);
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit_i) |=> !flag_o);
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
  a_r3_value_stable: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> $stable(cap_o));
endmodule

// File: rtl/icap_byteread.sv
module icap_byteread #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cap_i,
  input  logic               rd_lo_i,
  input  logic               rd_hi_i,
  output logic [CNT_W/2-1:0] rd_data_o
);
  localparam int unsigned BYTE_W = CNT_W / 2;

  logic [BYTE_W-1:0] hi_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_hold   <= '0;
      rd_data_o <= '0;
    end else if (rd_lo_i) begin
      rd_data_o <= cap_i[BYTE_W-1:0];
      hi_hold   <= cap_i[CNT_W-1:BYTE_W];
    end else if (rd_hi_i) begin
      rd_data_o <= hi_hold;
    end
  end

  a_r9_low_read: assert property (@(posedge clk) disable iff (rst)
    rd_lo_i |=> (rd_data_o == $past(cap_i[BYTE_W-1:0])));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_lo_i && !rd_hi_i) |=> $stable(rd_data_o));
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int unsigned CNT_W  = icap_pkg::DEF_CNT_W,
  parameter int unsigned STAGES = icap_pkg::DEF_SYNC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_pin_i,
  input  logic               rise_sel_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               flag_clr_i,
  input  logic               rd_lo_i,
  input  logic               rd_hi_i,
  output logic [CNT_W-1:0]   cap_value_o,
  output logic               cap_flag_o,
  output logic [CNT_W/2-1:0] rd_data_o
);
  localparam int unsigned WARM = STAGES + 1;

  logic pin_sync;
  logic hit;

  icap_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(cap_pin_i), .sync_o(pin_sync)
  );

  icap_edge #(.WARM(WARM)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(pin_sync), .rise_sel_i(rise_sel_i), .hit_o(hit)
  );

  icap_snapshot #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst(rst), .hit_i(hit), .clr_i(flag_clr_i), .count_i(count_i),
    .cap_o(cap_value_o), .flag_o(cap_flag_o)
  );

  icap_byteread #(.CNT_W(CNT_W)) u_read (
    .clk(clk), .rst(rst), .cap_i(cap_value_o), .rd_lo_i(rd_lo_i),
    .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o)
  );

  // R7: a capture while the flag is up still changes the stored value
  a_r7_overwrite: assert property (@(posedge clk) disable iff (rst)
    (hit && cap_flag_o) |=> (cap_value_o == $past(count_i)));
endmodule

// File: tb/icap_unit_bench.sv
module icap_unit_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_pin_i = 1'b1;
  logic        rise_sel_i = 1'b1;
  logic [15:0] count_i = '0;
  logic        flag_clr_i = 1'b0;
  logic        rd_lo_i = 1'b0;
  logic        rd_hi_i = 1'b0;
  logic [15:0] cap_value_o;
  logic        cap_flag_o;
  logic [7:0]  rd_data_o;

  int total = 0;
  int bad = 0;
  logic        m_flag = 1'b0;
  logic [15:0] m_cap = '0;

  always #(PERIOD/2) clk = ~clk;

  icap_unit u_icap_unit (
    .clk(clk), .rst(rst), .cap_pin_i(cap_pin_i), .rise_sel_i(rise_sel_i),
    .count_i(count_i), .flag_clr_i(flag_clr_i), .rd_lo_i(rd_lo_i),
    .rd_hi_i(rd_hi_i), .cap_value_o(cap_value_o), .cap_flag_o(cap_flag_o),
    .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Flip the pin and follow the capture through three edges.
  task automatic toggle_pin(input logic [15:0] v2, input logic clr_at_cap, input string req);
    logic fires;
    cap_pin_i = ~cap_pin_i;
    count_i   = ~v2;
    fires = (cap_pin_i == rise_sel_i);
    step(2);
    check({req, " R4 flag not yet"}, cap_flag_o, m_flag);
    count_i    = v2;
    flag_clr_i = clr_at_cap;
    step(1);
    flag_clr_i = 1'b0;
    if (fires) begin
      m_flag = 1'b1;
      m_cap  = v2;
    end else if (clr_at_cap) begin
      m_flag = 1'b0;
    end
    check({req, " R4 flag"}, cap_flag_o, m_flag);
    check({req, " R3 value"}, cap_value_o, m_cap);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    m_flag = 1'b0;
    check("R5 clear", cap_flag_o, 1'b0);
  endtask

  task automatic read_byte(input logic hi, input logic [7:0] exp, input string req);
    rd_lo_i = ~hi;
    rd_hi_i = hi;
    step(1);
    rd_lo_i = 1'b0;
    rd_hi_i = 1'b0;
    check(req, rd_data_o, exp);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(5);
    check("R10 reset flag", cap_flag_o, 1'b0);
    check("R10 reset value", cap_value_o, 16'h0);
    check("R10 reset rd_data", rd_data_o, 8'h0);

    // Sweep both polarities with alternating transitions (R1, R2, R3, R5, R7)
    for (int pol = 1; pol >= 0; pol--) begin
      rise_sel_i = pol[0];
      step(4);
      for (int i = 0; i < 32; i++) begin
        toggle_pin(16'((i * 16'h0813 + pol * 16'h8001) ^ 16'h5a5a), 1'b0,
                   pol == 1 ? "R1" : "R2");
        step(1);
        check("R5 flag held", cap_flag_o, m_flag);
        if (i % 8 == 5) clear_flag();
      end
    end

    // R7: capture overwrites while flag up
    rise_sel_i = 1'b1;
    if (cap_pin_i) toggle_pin(16'h0, 1'b0, "R7 prep");
    toggle_pin(16'h1111, 1'b0, "R7 first");
    toggle_pin(16'h2222, 1'b0, "R7 fall ignored");
    toggle_pin(16'h3333, 1'b0, "R7 second");
    check("R7 overwrite", cap_value_o, 16'h3333);

    // R6: clear on the capture edge
    toggle_pin(16'h4444, 1'b0, "R6 fall");
    clear_flag();
    toggle_pin(16'h5555, 1'b1, "R6");
    check("R6 capture beats clear", cap_flag_o, 1'b1);
    clear_flag();

    // R8: polarity flips with a quiet pin
    for (int k = 0; k < 4; k++) begin
      rise_sel_i = ~rise_sel_i;
      count_i = 16'(16'h7000 + k);
      step(4);
      check("R8 flag", cap_flag_o, 1'b0);
      check("R8 value", cap_value_o, m_cap);
    end

    // R9: byte reads, with a capture between low and high reads
    rise_sel_i = 1'b1;
    if (cap_pin_i) toggle_pin(16'h0, 1'b0, "R9 prep");
    toggle_pin(16'hA5C3, 1'b0, "R9 first");
    read_byte(1'b0, 8'hC3, "R9 low");
    toggle_pin(16'h0, 1'b0, "R9 fall");
    toggle_pin(16'h1234, 1'b0, "R9 between");
    read_byte(1'b1, 8'hA5, "R9 high parked");
    read_byte(1'b0, 8'h34, "R9 low new");
    read_byte(1'b1, 8'h12, "R9 high new");
    rd_lo_i = 1'b1;
    rd_hi_i = 1'b1;
    step(1);
    rd_lo_i = 1'b0;
    rd_hi_i = 1'b0;
    check("R9 both strobes", rd_data_o, 8'h34);

    // R10: reset with pin held high, no capture while warming up
    cap_pin_i = 1'b1;
    rise_sel_i = 1'b1;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(6);
    check("R10 no warmup capture", cap_flag_o, 1'b0);
    check("R10 value after reset", cap_value_o, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule